// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block turns one programmed-I/O request on an ATA channel into the address phase, the read or write strobe and the recovery gap that the bus needs. A requester presents a request with a drive number, a direction and a flag for command-block accesses. While the sequencer is idle it accepts the request, takes the timing fields that belong to that drive, and then walks through three timed phases before it signals completion.

Every drive's timing comes from two fields. The first is a 2-bit code for address setup, with a nonlinear mapping to clocks. The second is a byte that holds the strobe-active count and the recovery count as two nibbles. Command-block accesses use a separate timing byte instead. The recovery phase gets one extra clock when the chip revision input is above a threshold. A parameter chooses between two layouts. In the split layout each of the two drives has its own timing fields. In the shared layout a single set serves both drives, which is how the second channel of the controller works.

Top module: `pio_strobe_timer`

## Requirements
- R1: While reset is low, and after it is released with no request, `busy`, `addr_phase`, `rd_strobe`, `wr_strobe` and `done` are all 0.
- R2: The setup code picks how many clocks `addr_phase` is high: 00 gives 4 clocks, 01 gives 2, 10 gives 3 and 11 gives 5. `addr_phase` goes high in the first cycle after the request is accepted.
- R3: The timing byte's upper nibble is the strobe-active count. Nibble 0 means 16 clocks and nibble 1 is raised to 2 clocks. The strobe rises in the cycle right after the last setup cycle.
- R4: The lower nibble is the recovery count. Nibble 0 means 16 clocks and nibble 1 is raised to 2 clocks. When `chip_rev` is greater than 1, one more recovery clock is added, so the longest recovery is 17 clocks.
- R5: `rd_strobe` (for `req_write`=0) or `wr_strobe` (for `req_write`=1) is high only during the active phase. The two strobes are never high together, and neither is high together with `addr_phase`.
- R6: `busy` is high from the cycle after acceptance to the last recovery clock. `done` is high for exactly one clock, in the first cycle after the last recovery clock.
- R7: With SHARED_TIMING=0, drive d uses setup code bits [2d+1:2d] and timing byte bits [8d+7:8d]. With SHARED_TIMING=1, both drives use the single set. `cur_drive` shows the accepted drive for as long as `busy` is high.
- R8: When `req_cmd_blk`=1, the active and recovery nibbles come from `cmd_timing` and setup lasts CMD_SETUP_CLKS (default 5) clocks. `cmd_timing`=0 gives 16 active and 16 recovery clocks, plus the revision clock when it applies.
- R9: A request raised while `busy` is high is not accepted until the sequencer is idle again. Changing the timing inputs after acceptance has no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request, accepted while idle |
| req_drive | input | 1 | Drive number of the request |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_cmd_blk | input | 1 | Use the command-block timing byte |
| chip_rev | input | REV_W | Chip revision field |
| setup_codes | input | 2*N_SETS | Setup codes, one 2-bit field for each timing set |
| rw_timing | input | 8*N_SETS | Active/recovery bytes, one for each timing set |
| cmd_timing | input | 8 | Active/recovery byte for command-block accesses |
| busy | output | 1 | A transfer cycle is in progress |
| addr_phase | output | 1 | Address setup phase |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| done | output | 1 | One-clock completion pulse |
| cur_drive | output | 1 | Drive of the current cycle |

## Verification
The bench builds two instances side by side. One uses SHARED_TIMING=0 and the other SHARED_TIMING=1, and both run with NIB_W=4 and CMD_SETUP_CLKS=5. Driving the same requests into both shows the difference directly: a drive-1 request uses its own timing set on the split instance and set 0 on the shared one. The 4-bit nibbles make the 16-clock and 17-clock extremes short enough to exercise in full. Revisions 1, 2 and 3 cover both sides of the recovery-offset threshold.

// File: rtl/pio_tim_pkg.sv
package pio_tim_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_RECOV  = 2'd3
   } pio_phase_e;

   localparam int SETUP_CODE_W = 2;

endpackage

// File: rtl/pio_count_decode.sv
module pio_count_decode #(
   parameter int NIB_W          = 4,
   parameter int REV_W          = 2,
   parameter int REV_THRESH     = 1,
   parameter int CMD_SETUP_CLKS = 5,
   parameter int CNT_W          = NIB_W + 1
) (
   input  logic             use_cmd,
   input  logic [1:0]       setup_code,
   input  logic [NIB_W-1:0] act_nib,
   input  logic [NIB_W-1:0] rec_nib,
   input  logic [REV_W-1:0] chip_rev,
   output logic [CNT_W-1:0] setup_clks,
   output logic [CNT_W-1:0] act_clks,
   output logic [CNT_W-1:0] rec_clks
);

   localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(2 ** NIB_W);
   localparam logic [CNT_W-1:0] MIN_CNT   = CNT_W'(2);
   localparam logic [CNT_W-1:0] CMD_SETUP = CNT_W'(CMD_SETUP_CLKS);

   logic [CNT_W-1:0] rec_base;
   logic             rev_extra;

   // nonlinear setup code
   always_comb begin
      if (use_cmd) begin
         setup_clks = CMD_SETUP;
      end else begin
         unique case (setup_code)
            2'b00:   setup_clks = CNT_W'(4);
            2'b10:   setup_clks = CNT_W'(3);
            2'b01:   setup_clks = CNT_W'(2);
            default: setup_clks = CNT_W'(5);
         endcase
      end
   end

   // active nibble: zero wraps to full, one is raised to the minimum
   always_comb begin
      if (act_nib == '0)
         act_clks = FULL_CNT;
      else if (act_nib == NIB_W'(1))
         act_clks = MIN_CNT;
      else
         act_clks = {1'b0, act_nib};
   end

   // recovery nibble plus revision-dependent extra clock
   always_comb begin
      if (rec_nib == '0)
         rec_base = FULL_CNT;
      else if (rec_nib < NIB_W'(2))
         rec_base = MIN_CNT;
      else
         rec_base = {1'b0, rec_nib};
      rev_extra = (chip_rev > REV_W'(REV_THRESH));
      rec_clks  = rec_base + {{(CNT_W-1){1'b0}}, rev_extra};
   end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
   import pio_tim_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_drive,
   input  logic             req_write,
   input  logic [CNT_W-1:0] setup_clks,
   input  logic [CNT_W-1:0] act_clks,
   input  logic [CNT_W-1:0] rec_clks,
   output logic             busy,
   output logic             addr_phase,
   output logic             rd_strobe,
   output logic             wr_strobe,
   output logic             done,
   output logic             cur_drive
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   pio_phase_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] act_q;
   logic [CNT_W-1:0] rec_q;
   logic             wr_q;
   logic             drv_q;
   logic             done_q;
   logic             last_clk;

   assign last_clk = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PH_IDLE;
         cnt_q  <= '0;
         act_q  <= '0;
         rec_q  <= '0;
         wr_q   <= 1'b0;
         drv_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            PH_IDLE: begin
               if (req_valid) begin
                  st_q  <= PH_SETUP;
                  cnt_q <= setup_clks - ONE;
                  act_q <= act_clks;
                  rec_q <= rec_clks;
                  wr_q  <= req_write;
                  drv_q <= req_drive;
               end
            end
            PH_SETUP: begin
               if (last_clk) begin
                  st_q  <= PH_ACTIVE;
                  cnt_q <= act_q - ONE;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
            PH_ACTIVE: begin
               if (last_clk) begin
                  st_q  <= PH_RECOV;
                  cnt_q <= rec_q - ONE;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
            PH_RECOV: begin
               if (last_clk) begin
                  st_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
         endcase
      end
   end

   assign busy       = (st_q != PH_IDLE);
   assign addr_phase = (st_q == PH_SETUP);
   assign rd_strobe  = (st_q == PH_ACTIVE) && !wr_q;
   assign wr_strobe  = (st_q == PH_ACTIVE) && wr_q;
   assign done       = done_q;
   assign cur_drive  = drv_q;

   AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_strobe || wr_strobe) |-> $past(addr_phase)); // R5

   AST_ACTIVE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_strobe || wr_strobe) |=> (rd_strobe || wr_strobe)); // R3

   AST_RECOVERY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_strobe || wr_strobe) |-> !done ##1 !done); // R4

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_phase) |-> $past(!busy)); // R9

   AST_DRIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cur_drive)); // R7

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
   import pio_tim_pkg::*;
#(
   parameter int NIB_W          = 4,
   parameter int REV_W          = 2,
   parameter int REV_THRESH     = 1,
   parameter int SHARED_TIMING  = 0,
   parameter int CMD_SETUP_CLKS = 5,
   localparam int TIM_W         = 2 * NIB_W,
   localparam int N_SETS        = (SHARED_TIMING != 0) ? 1 : 2,
   localparam int CNT_W         = NIB_W + 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   input  logic                             req_drive,
   input  logic                             req_write,
   input  logic                             req_cmd_blk,
   input  logic [REV_W-1:0]                 chip_rev,
   input  logic [N_SETS*SETUP_CODE_W-1:0]   setup_codes,
   input  logic [N_SETS*TIM_W-1:0]          rw_timing,
   input  logic [TIM_W-1:0]                 cmd_timing,
   output logic                             busy,
   output logic                             addr_phase,
   output logic                             rd_strobe,
   output logic                             wr_strobe,
   output logic                             done,
   output logic                             cur_drive
);

   // elaboration checks
   if (NIB_W < 2) begin : g_bad_nib
      $error("NIB_W must be at least 2");
   end
   if (CMD_SETUP_CLKS < 1 || CMD_SETUP_CLKS >= (2 ** CNT_W)) begin : g_bad_cmd
      $error("CMD_SETUP_CLKS out of counter range");
   end
   if (SHARED_TIMING != 0 && SHARED_TIMING != 1) begin : g_bad_share
      $error("SHARED_TIMING must be 0 or 1");
   end

   logic [SETUP_CODE_W-1:0] code_sel;
   logic [TIM_W-1:0]        rw_sel;
   logic [NIB_W-1:0]        act_nib;
   logic [NIB_W-1:0]        rec_nib;
   logic [CNT_W-1:0]        setup_clks;
   logic [CNT_W-1:0]        act_clks;
   logic [CNT_W-1:0]        rec_clks;

   // timing set selection
   if (N_SETS == 1) begin : g_shared
      assign code_sel = setup_codes;
      assign rw_sel   = rw_timing;
   end else begin : g_split
      assign code_sel = req_drive ? setup_codes[2*SETUP_CODE_W-1:SETUP_CODE_W]
                                  : setup_codes[SETUP_CODE_W-1:0];
      assign rw_sel   = req_drive ? rw_timing[2*TIM_W-1:TIM_W]
                                  : rw_timing[TIM_W-1:0];
   end

   assign act_nib = req_cmd_blk ? cmd_timing[TIM_W-1:NIB_W] : rw_sel[TIM_W-1:NIB_W];
   assign rec_nib = req_cmd_blk ? cmd_timing[NIB_W-1:0]     : rw_sel[NIB_W-1:0];

   pio_count_decode #(
      .NIB_W          (NIB_W),
      .REV_W          (REV_W),
      .REV_THRESH     (REV_THRESH),
      .CMD_SETUP_CLKS (CMD_SETUP_CLKS),
      .CNT_W          (CNT_W)
   ) u_decode (
      .use_cmd    (req_cmd_blk),
      .setup_code (code_sel),
      .act_nib    (act_nib),
      .rec_nib    (rec_nib),
      .chip_rev   (chip_rev),
      .setup_clks (setup_clks),
      .act_clks   (act_clks),
      .rec_clks   (rec_clks)
   );

   pio_phase_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_drive  (req_drive),
      .req_write  (req_write),
      .setup_clks (setup_clks),
      .act_clks   (act_clks),
      .rec_clks   (rec_clks),
      .busy       (busy),
      .addr_phase (addr_phase),
      .rd_strobe  (rd_strobe),
      .wr_strobe  (wr_strobe),
      .done       (done),
      .cur_drive  (cur_drive)
   );

   AST_NO_PHASE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(addr_phase || rd_strobe || wr_strobe)); // R1

   AST_DONE_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy)); // R6

endmodule

// File: tb/pio_strobe_timer_tb.sv
module pio_strobe_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_drive = 1'b0;
   logic        req_write = 1'b0;
   logic        req_cmd_blk = 1'b0;
   logic [1:0]  chip_rev = 2'd1;
   logic [3:0]  codes = 4'b0000;
   logic [15:0] rwt = 16'h0000;
   logic [7:0]  cmdt = 8'h00;

   logic p_busy, p_addr, p_rd, p_wr, p_done, p_drv;
   logic s_busy, s_addr, s_rd, s_wr, s_done, s_drv;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   string cur_tag = "R1";

   always #10 clk = ~clk;   // 50 MHz

   pio_strobe_timer #(.SHARED_TIMING(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_drive(req_drive),
      .req_write(req_write), .req_cmd_blk(req_cmd_blk), .chip_rev(chip_rev),
      .setup_codes(codes), .rw_timing(rwt), .cmd_timing(cmdt),
      .busy(p_busy), .addr_phase(p_addr), .rd_strobe(p_rd), .wr_strobe(p_wr),
      .done(p_done), .cur_drive(p_drv));

   pio_strobe_timer #(.SHARED_TIMING(1)) u_dut_sec (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_drive(req_drive),
      .req_write(req_write), .req_cmd_blk(req_cmd_blk), .chip_rev(chip_rev),
      .setup_codes(codes[1:0]), .rw_timing(rwt[7:0]), .cmd_timing(cmdt),
      .busy(s_busy), .addr_phase(s_addr), .rd_strobe(s_rd), .wr_strobe(s_wr),
      .done(s_done), .cur_drive(s_drv));

   // behavioural reference: remaining clocks of each phase, per instance
   int rs[2], ra[2], rr[2];
   bit mwr[2], mdrv[2], mdone[2];

   function automatic int setup_of(int code);
      case (code)
         0: return 4;
         2: return 3;
         1: return 2;
         default: return 5;
      endcase
   endfunction

   always @(posedge clk) begin
      for (int m = 0; m < 2; m++) begin
         if (!rst_n) begin
            rs[m] = 0; ra[m] = 0; rr[m] = 0; mdone[m] = 0; mwr[m] = 0; mdrv[m] = 0;
         end else begin
            mdone[m] = 0;
            if (rs[m] + ra[m] + rr[m] == 0) begin
               if (req_valid) begin
                  int set_i, an, rn, byte_v;
                  set_i = (m == 1) ? 0 : int'(req_drive);
                  byte_v = req_cmd_blk ? int'(cmdt) : int'(rwt[set_i*8 +: 8]);
                  an = byte_v / 16;
                  rn = byte_v % 16;
                  rs[m] = req_cmd_blk ? 5 : setup_of(int'(codes[set_i*2 +: 2]));
                  ra[m] = (an == 0) ? 16 : ((an == 1) ? 2 : an);
                  rr[m] = (rn == 0) ? 16 : ((rn == 1) ? 2 : rn);
                  if (chip_rev > 2'd1) rr[m] = rr[m] + 1;
                  mwr[m] = req_write;
                  mdrv[m] = req_drive;
               end
            end else if (rs[m] > 0) begin
               rs[m] = rs[m] - 1;
            end else if (ra[m] > 0) begin
               ra[m] = ra[m] - 1;
            end else begin
               rr[m] = rr[m] - 1;
               if (rr[m] == 0) mdone[m] = 1;
            end
         end
      end
   end

   task automatic chk(string sig_tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s (scenario %s) %s: actual=%0d expected=%0d at %0t",
                  sig_tag, cur_tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         for (int m = 0; m < 2; m++) begin
            bit ebusy, eaddr, erd, ewr;
            ebusy = (rs[m] + ra[m] + rr[m]) > 0;
            eaddr = rs[m] > 0;
            erd = (rs[m] == 0) && (ra[m] > 0) && !mwr[m];
            ewr = (rs[m] == 0) && (ra[m] > 0) && mwr[m];
            chk("R6", m ? "sec busy" : "pri busy", int'(m ? s_busy : p_busy), int'(ebusy));
            chk("R2", m ? "sec addr_phase" : "pri addr_phase", int'(m ? s_addr : p_addr), int'(eaddr));
            chk("R5", m ? "sec rd_strobe" : "pri rd_strobe", int'(m ? s_rd : p_rd), int'(erd));
            chk("R5", m ? "sec wr_strobe" : "pri wr_strobe", int'(m ? s_wr : p_wr), int'(ewr));
            chk("R6", m ? "sec done" : "pri done", int'(m ? s_done : p_done), int'(mdone[m]));
            if (ebusy)
               chk("R7", m ? "sec cur_drive" : "pri cur_drive", int'(m ? s_drv : p_drv), int'(mdrv[m]));
         end
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while ((rs[0] + ra[0] + rr[0] + rs[1] + ra[1] + rr[1]) != 0) @(negedge clk);
   endtask

   task automatic issue(bit drv, bit wr, bit cmd);
      @(negedge clk);
      req_drive = drv; req_write = wr; req_cmd_blk = cmd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      cur_tag = "R1";
      chk("R1", "busy in reset", int'(p_busy | s_busy), 0);
      chk("R1", "strobes in reset", int'(p_rd | p_wr | s_rd | s_wr | p_addr | s_addr), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "outputs idle after reset", int'(p_busy | p_done | s_busy | s_done), 0);

      // R2/R3/R4: plain nibbles, code 00, revision 1
      cur_tag = "R2";
      chip_rev = 2'd1; codes = 4'b10_00; rwt = 16'h00_35;
      issue(1'b0, 1'b0, 1'b0);
      // R3/R4 zero nibbles on drive 1, code 10, revision 2 (17 recovery)
      cur_tag = "R4";
      chip_rev = 2'd2;
      issue(1'b1, 1'b1, 1'b0);
      // R3/R4 minima: code 01, nibbles 1/1, revision 1
      cur_tag = "R3";
      chip_rev = 2'd1; codes = 4'b11_01; rwt = 16'h21_11;
      issue(1'b0, 1'b1, 1'b0);
      // R7: drive 1 uses own set on split, set 0 on shared; revision 3
      cur_tag = "R7";
      chip_rev = 2'd3;
      issue(1'b1, 1'b0, 1'b0);
      // R8: command block timing, slowest byte
      cur_tag = "R8";
      cmdt = 8'h00; chip_rev = 2'd1;
      issue(1'b0, 1'b0, 1'b1);
      cmdt = 8'h42; chip_rev = 2'd2;
      issue(1'b1, 1'b1, 1'b1);

      // R9: request held off while busy, timing changes after acceptance
      cur_tag = "R9";
      chip_rev = 2'd1; codes = 4'b00_00; rwt = 16'h00_00;
      @(negedge clk);
      req_drive = 1'b0; req_write = 1'b0; req_cmd_blk = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      codes = 4'b11_11; rwt = 16'h22_22; chip_rev = 2'd3;
      repeat (3) @(negedge clk);
      req_drive = 1'b1; req_write = 1'b1; req_valid = 1'b1;
      repeat (6) @(negedge clk);
      req_valid = 1'b0;
      wait_idle();

      // R6: back-to-back accepts with the request held high
      cur_tag = "R6";
      chip_rev = 2'd1; codes = 4'b01_11; rwt = 16'h11_37;
      @(negedge clk);
      req_drive = 1'b1; req_write = 1'b1; req_cmd_blk = 1'b0; req_valid = 1'b1;
      repeat (60) @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL R6 watchdog: actual=hung expected=cycle completion");
         summary();
         $finish;
      end
   end

endmodule